// File: doc/BRIEF.md
# Quarter-Turn PSK Hard-Decision Demapper

This block sits behind the frequency-domain equalizer and its inverse transform in a single-carrier receiver. It accepts one equalized complex sample per valid cycle and produces two results from it. The first is a hard decision symbol that goes back to the adaptive equalizer as its error reference. The second is the recovered data bits. The transmitter turns each successive constellation point a quarter turn counterclockwise. The demapper therefore undoes one clockwise quarter turn per symbol index, using a two-bit phase counter that restarts on the first symbol of each data block.

Slicing happens in the received, still-rotated frame. For the four-point mode, the quarter turn maps the quadrant boundaries onto themselves, so the sign of each axis is the decision. For the two-point mode, the decision alternates between the sign of the real axis at even symbol indices and the sign of the imaginary axis at odd ones. The decision symbol is returned in the same rotated frame as the input, so no re-rotation is needed on the feedback path. Derotation is applied only to the sign bits that become data bits. It is a swap of the two axes with one inversion, and needs no multiplier.

Top module: `rot_psk_demapper`

## Requirements
- R1: While rst_n is sampled low at a rising edge, out_valid, out_bits, dec_i and dec_q are all cleared to zero on that edge.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. The outputs for a symbol appear one clock after it is accepted.
- R3: The rotation phase of an accepted symbol is 0 when in_blk_start is high, and otherwise it is the phase of the previous accepted symbol plus one, modulo 4. Cycles with in_valid low do not advance the phase, and in those cycles in_blk_start has no effect. The first symbol after reset has phase 0.
- R4: In four-point mode (mode = 1), dec_i is +A when in_i is at least zero and -A otherwise, and dec_q follows the same rule from in_q. A is 2^UNIT_SHIFT. Both values stay in the received, rotated frame.
- R5: In four-point mode, the axis signs are rotated clockwise by phase quarter turns, where one quarter turn maps (I,Q) to (Q,-I). out_bits[0] is then 1 when the derotated I is negative, and out_bits[1] is 1 when the derotated Q is negative.
- R6: In two-point mode (mode = 0) at an even phase, dec_i is ±A from the sign of in_i and dec_q is 0. The value of in_q has no effect on any output.
- R7: In two-point mode at an odd phase, dec_q is ±A from the sign of in_q and dec_i is 0. The value of in_i has no effect on any output.
- R8: In two-point mode, out_bits[0] is 1 when the sliced point, rotated clockwise by phase quarter turns, lies on the negative real axis. This is the sign of in_i for phase 0, of in_q for phase 1, the inverse sign of in_i for phase 2, and the inverse sign of in_q for phase 3. out_bits[1] is 0.
- R9: An axis value of exactly zero is decided as positive (+A, sign bit 0).
- R10: In a cycle after one with in_valid low, out_bits, dec_i and dec_q keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An equalized sample is present this cycle |
| in_blk_start | input | 1 | Marks the first symbol of a data block (phase 0) |
| mode | input | 1 | 0 = two-point, 1 = four-point constellation |
| in_i | input | W | Equalized real part, two's complement |
| in_q | input | W | Equalized imaginary part, two's complement |
| out_valid | output | 1 | Results for the previous accepted sample |
| out_bits | output | 2 | Demapped bits; only bit 0 is used in two-point mode |
| dec_i | output | W | Real part of the decision symbol, rotated frame |
| dec_q | output | W | Imaginary part of the decision symbol, rotated frame |

## Verification
The bench drives random samples in all four quadrants, in both modes. The samples arrive with random gaps and random block restarts, so every phase is paired with every sign combination. This distinguishes a wrong derotation direction or axis swap from a correct one. Directed runs use exact zeros and the most negative input value to check the tie rule and sign handling. Runs in two-point mode put large opposite-sign values on the unused axis, to show that it is ignored at each parity. A restart marker sent in an idle cycle, followed by a symbol, shows that the marker is ignored without a valid sample.

// File: rtl/rot_psk_pkg.sv
// Shared types for the quarter-turn PSK demapper.
package rot_psk_pkg;
    // Constellation selection carried on the mode pin.
    typedef enum logic {
        MODE_BPSK = 1'b0,
        MODE_QPSK = 1'b1
    } psk_mode_e;
endpackage

// File: rtl/rot_phase_ctr.sv
// Symbol rotation phase tracker.
// Gives the quarter-turn index of the symbol presented this cycle.
// Assumes one symbol per cycle with sym_valid high. A block start forces
// phase 0 for that symbol. Idle cycles leave the phase untouched.
module rot_phase_ctr #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_valid,
    input  logic          blk_start,
    output logic [PW-1:0] phase
);
    logic [PW-1:0] next_idx;

    // Current symbol phase: restart value on a block start, stored index otherwise.
    always_comb phase = blk_start ? '0 : next_idx;

    // Advance the stored index past each accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)
            next_idx <= '0;
        else if (sym_valid)
            next_idx <= phase + 1'b1;
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(next_idx));
    // R3
    restart_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && blk_start) |=> (next_idx == PW'(1)));
endmodule

// File: rtl/rot_psk_slicer.sv
// Hard slicer working in the received (rotated) frame.
// Uses only the axis sign bits. Four-point mode decides both axes.
// Two-point mode decides the real axis at even phases and the imaginary
// axis at odd phases, and zeroes the other axis.
// Assumes a sign bit of 0 (zero or positive) means +AMP.
module rot_psk_slicer #(
    parameter int W   = 12,
    parameter int AMP = 512
) (
    input  rot_psk_pkg::psk_mode_e mode,
    input  logic                   odd_phase,
    input  logic                   sgn_i,
    input  logic                   sgn_q,
    output logic signed [W-1:0]    slice_i,
    output logic signed [W-1:0]    slice_q
);
    import rot_psk_pkg::*;

    localparam logic signed [W-1:0] POS = W'(AMP);
    localparam logic signed [W-1:0] NEG = W'(-AMP);

    logic signed [W-1:0] lvl_i, lvl_q;

    // Unit-amplitude level for each axis from its sign.
    always_comb begin
        lvl_i = sgn_i ? NEG : POS;
        lvl_q = sgn_q ? NEG : POS;
    end

    // Choose which axes carry a decision for the selected constellation.
    always_comb begin
        if (mode == MODE_QPSK) begin
            slice_i = lvl_i;
            slice_q = lvl_q;
        end else if (odd_phase) begin
            slice_i = '0;
            slice_q = lvl_q;
        end else begin
            slice_i = lvl_i;
            slice_q = '0;
        end
    end
endmodule

// File: rtl/rot_psk_bitmap.sv
// Derotating bit mapper.
// Turns the rotated-frame axis signs clockwise by phase quarter turns.
// One quarter turn maps (I,Q) to (Q,-I), which is a swap plus an
// inversion of sign bits. The derotated signs are then read as
// Gray-coded bits.
// Two-point mode gives a single bit from the derotated real sign. The
// parity-selected axis already holds that value.
module rot_psk_bitmap #(
    parameter int PW = 2
) (
    input  rot_psk_pkg::psk_mode_e mode,
    input  logic [PW-1:0]          phase,
    input  logic                   sgn_i,
    input  logic                   sgn_q,
    output logic [1:0]             bits
);
    import rot_psk_pkg::*;

    logic d_i, d_q;

    // Clockwise derotation of the sign pair by the low two phase bits.
    always_comb begin
        unique case (phase[1:0])
            2'd0:    begin d_i = sgn_i;  d_q = sgn_q;  end
            2'd1:    begin d_i = sgn_q;  d_q = ~sgn_i; end
            2'd2:    begin d_i = ~sgn_i; d_q = ~sgn_q; end
            default: begin d_i = ~sgn_q; d_q = sgn_i;  end
        endcase
    end

    // Pack bits: both derotated signs, or only the real one in two-point mode.
    always_comb begin
        if (mode == MODE_QPSK)
            bits = {d_q, d_i};
        else
            bits = {1'b0, d_i};
    end
endmodule

// File: rtl/rot_psk_demapper.sv
// Quarter-turn PSK hard-decision demapper (top).
// Slices each equalized sample in its rotated frame and returns that
// decision for equalizer feedback. Derotates only the decided signs to
// form the data bits. One register stage; the outputs hold between
// valid samples.
// Assumes UNIT_SHIFT < W-1, so +/-2^UNIT_SHIFT fits in W signed bits.
module rot_psk_demapper #(
    parameter int W          = 12,
    parameter int UNIT_SHIFT = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_blk_start,
    input  logic                mode,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    output logic                out_valid,
    output logic [1:0]          out_bits,
    output logic signed [W-1:0] dec_i,
    output logic signed [W-1:0] dec_q
);
    import rot_psk_pkg::*;

    localparam int PW  = 2;
    localparam int AMP = 1 << UNIT_SHIFT;
    localparam logic signed [W-1:0] POS = W'(AMP);
    localparam logic signed [W-1:0] NEG = W'(-AMP);

    psk_mode_e           mode_e;
    logic [PW-1:0]       phase;
    logic                sgn_i, sgn_q;
    logic signed [W-1:0] slice_i, slice_q;
    logic [1:0]          bits;

    // Decode the mode pin and pick off the axis sign bits (zero counts as positive).
    always_comb begin
        mode_e = psk_mode_e'(mode);
        sgn_i  = in_i[W-1];
        sgn_q  = in_q[W-1];
    end

    rot_phase_ctr #(.PW(PW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (in_valid),
        .blk_start (in_blk_start),
        .phase     (phase)
    );

    rot_psk_slicer #(.W(W), .AMP(AMP)) u_slice (
        .mode      (mode_e),
        .odd_phase (phase[0]),
        .sgn_i     (sgn_i),
        .sgn_q     (sgn_q),
        .slice_i   (slice_i),
        .slice_q   (slice_q)
    );

    rot_psk_bitmap #(.PW(PW)) u_bits (
        .mode  (mode_e),
        .phase (phase),
        .sgn_i (sgn_i),
        .sgn_q (sgn_q),
        .bits  (bits)
    );

    // Valid flag follows the input one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Capture decision and bits for each accepted sample; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bits <= '0;
            dec_i    <= '0;
            dec_q    <= '0;
        end else if (in_valid) begin
            out_bits <= bits;
            dec_i    <= slice_i;
            dec_q    <= slice_q;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dec_i) && $stable(dec_q) && $stable(out_bits)));
    // R4
    qpsk_both_axes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_e == MODE_QPSK) |=>
            ((dec_i == POS || dec_i == NEG) && (dec_q == POS || dec_q == NEG)));
    // R6
    bpsk_even_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_e == MODE_BPSK && !phase[0]) |=>
            ((dec_i == POS || dec_i == NEG) && dec_q == '0));
    // R7
    bpsk_odd_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_e == MODE_BPSK && phase[0]) |=>
            (dec_i == '0 && (dec_q == POS || dec_q == NEG)));
    // R8
    bpsk_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_e == MODE_BPSK) |=> (out_bits[1] == 1'b0));
    // R9
    zero_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_e == MODE_QPSK && in_i == '0) |=> (dec_i == POS));
endmodule

// File: tb/rot_psk_demapper_bench.sv
// Self-checking bench: seeded random traffic plus directed corner cases.
module rot_psk_demapper_bench;
    localparam int W          = 12;
    localparam int UNIT_SHIFT = 9;
    localparam int AMP        = 1 << UNIT_SHIFT;
    localparam int MAXN       = -(1 << (W-1));
    localparam int MAXP       = (1 << (W-1)) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_blk_start = 1'b0;
    logic                mode = 1'b0;
    logic signed [W-1:0] in_i = '0;
    logic signed [W-1:0] in_q = '0;
    logic                out_valid;
    logic [1:0]          out_bits;
    logic signed [W-1:0] dec_i;
    logic signed [W-1:0] dec_q;

    int n_checks = 0;
    int n_fail   = 0;
    int ph_cnt   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    rot_psk_demapper #(.W(W), .UNIT_SHIFT(UNIT_SHIFT)) u_rot_psk_demapper (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_blk_start (in_blk_start),
        .mode         (mode),
        .in_i         (in_i),
        .in_q         (in_q),
        .out_valid    (out_valid),
        .out_bits     (out_bits),
        .dec_i        (dec_i),
        .dec_q        (dec_q)
    );

    function automatic int sgnv(int v);
        return (v >= 0) ? 1 : -1;
    endfunction

    // Expected decision and bits from the requirements, via an explicit complex turn.
    function automatic void model(input bit m, input int p, input int vi, input int vq,
                                  output int ei, output int eq, output int eb);
        int ri, rq, t;
        if (m) begin
            ei = sgnv(vi); eq = sgnv(vq);
        end else if (p % 2 == 0) begin
            ei = sgnv(vi); eq = 0;
        end else begin
            ei = 0; eq = sgnv(vq);
        end
        ri = ei; rq = eq;
        for (int k = 0; k < p; k++) begin
            t = ri; ri = rq; rq = -t;
        end
        if (m) eb = ((rq < 0) ? 2 : 0) + ((ri < 0) ? 1 : 0);
        else   eb = (ri < 0) ? 1 : 0;
        ei = ei * AMP; eq = eq * AMP;
    endfunction

    task automatic check(input bit ok, input string tag, input string got, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %s expected %s", tag, got, exp);
        end
    endtask

    // Drive one cycle at a falling edge and check the outputs at the next falling edge.
    task automatic step(input bit v, input bit st, input bit m, input int vi, input int vq);
        int p, ei, eq, eb;
        int pi_, pq_, pb;
        string tag;
        pi_ = int'(dec_i); pq_ = int'(dec_q); pb = int'(out_bits);
        in_valid = v; in_blk_start = st; mode = m;
        in_i = W'(vi); in_q = W'(vq);
        p = st ? 0 : ph_cnt;
        if (v) ph_cnt = (p + 1) % 4;
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            model(m, p, vi, vq, ei, eq, eb);
            if (m) tag = "R4 R5 R3 R9";
            else if (p % 2 == 0) tag = "R6 R8 R3 R9";
            else tag = "R7 R8 R3 R9";
            check(out_valid && int'(dec_i) == ei && int'(dec_q) == eq && int'(out_bits) == eb,
                  $sformatf("%s R2 ph=%0d", tag, p),
                  $sformatf("v=%0d i=%0d q=%0d b=%0d", out_valid, dec_i, dec_q, out_bits),
                  $sformatf("v=1 i=%0d q=%0d b=%0d", ei, eq, eb));
        end else begin
            check(!out_valid && int'(dec_i) == pi_ && int'(dec_q) == pq_ && int'(out_bits) == pb,
                  "R10 R2 idle",
                  $sformatf("v=%0d i=%0d q=%0d b=%0d", out_valid, dec_i, dec_q, out_bits),
                  $sformatf("v=0 i=%0d q=%0d b=%0d", pi_, pq_, pb));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2741));
        in_valid = 1'b1; in_i = 12'sd100; in_q = -12'sd100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while in reset
        check(!out_valid && dec_i == 0 && dec_q == 0 && out_bits == 0, "R1 reset",
              $sformatf("v=%0d i=%0d q=%0d b=%0d", out_valid, dec_i, dec_q, out_bits), "all zero");
        in_valid = 1'b0;
        rst_n = 1'b1;
        ph_cnt = 0;

        // Directed: four-point mode through all phases, one quadrant each.
        step(1, 0, 1, 300, 200);
        step(1, 0, 1, -300, 200);
        step(1, 0, 1, -300, -200);
        step(1, 0, 1, 300, -200);
        // R9: exact zeros and extreme values
        step(1, 1, 1, 0, 0);
        step(1, 0, 1, MAXN, 0);
        step(1, 0, 1, 0, MAXN);
        step(1, 0, 1, MAXP, MAXN);
        // R6, R7: the unused axis is loaded with a large opposite-sign value
        step(1, 1, 0, 5, MAXN);
        step(1, 0, 0, MAXN, 7);
        step(1, 0, 0, -5, MAXP);
        step(1, 0, 0, MAXP, -7);
        step(1, 0, 0, 0, MAXN);
        step(1, 0, 0, MAXN, 0);
        // R3: a start marker in an idle cycle is ignored, then a symbol continues the count
        step(0, 1, 0, 0, 0);
        step(1, 0, 0, 50, -50);
        step(0, 0, 1, MAXN, MAXN);
        step(1, 1, 0, -50, 50);

        // Random traffic.
        for (int n = 0; n < 3000; n++) begin
            bit v, st, m;
            int vi, vq;
            v  = ($urandom % 4) != 0;
            st = ($urandom % 12) == 0;
            m  = $urandom % 2;
            vi = int'($signed(W'($urandom)));
            vq = int'($signed(W'($urandom)));
            if ($urandom % 16 == 0) vi = 0;
            if ($urandom % 16 == 0) vq = 0;
            step(v, st, m, vi, vq);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule